// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 32 interrupt inputs and drives two request lines toward a processor core. One line is a fast request, fed only by source 0. The other is a normal request, fed by sources 1 to 31 through a priority selector. Each source has its own configuration word, which sets its trigger type and a priority from 0 to 7. Each source also has its own vector word.

Software services a normal interrupt in three steps. It reads the normal vector location, which returns the vector of the winning source and records that source as in service. It runs the handler. It then writes the end-of-service location, which returns the controller to the priority level that was active before. While a source is in service, only a strictly higher priority source can raise the normal request again, so up to eight levels can nest.

If a request disappears before its vector is read, the read returns a programmable spurious vector and the service state does not change. All registers sit on a simple synchronous word-addressed bus. Read data is registered.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, both request lines are low, and the pending, mask, status and read-data values are all zero.
- R2: Configuration word bits [2:0] hold the priority and bits [6:5] hold the trigger type. Type 00 is active-low level, 01 is falling edge, 10 is active-high level and 11 is rising edge. A level source's pending bit follows its input one clock later.
- R3: An edge source's pending bit is set one clock after the selected edge. It stays set after the input returns, until a clear command or a vector acknowledge removes it.
- R4: The enable command sets mask bits and the disable command clears them, one bit per source, from the clock after the write. A pending source whose mask bit is clear raises no request.
- R5: The set and clear commands force and remove pending bits of edge sources from the clock after the write. These commands have no effect on level sources.
- R6: Among pending, enabled sources 1..31, the winner is the one with the highest priority. On equal priority, the lower source number wins.
- R7: A normal-vector read while the normal request is high returns the winner's vector and clears its pending bit if it is edge-triggered. The read also makes the winner the current in-service source. The normal request then stays low until a source of strictly higher priority is pending and enabled.
- R8: A write to the end-of-service location drops the current in-service source and restores the previous one. This nests to 8 levels. The status word reports the current in-service source number in bits [4:0], or 0 when none is in service.
- R9: Source 0 alone drives the fast request. A fast-vector read while the fast request is high returns vector 0 and clears source 0's pending bit if it is edge-triggered.
- R10: A vector read with its request line low returns the spurious vector and changes no state. The spurious vector is readable and writable.
- R11: The core status word shows the fast request in bit 0 and the normal request in bit 1.
- R12: Word addresses are as follows. Configuration words for sources 0..31 are at 0..31, and vector words for sources 0..31 are at 32..63. The other locations are:
  - 64: normal vector
  - 65: fast vector
  - 66: status
  - 67: pending
  - 68: mask
  - 69: core status
  - 72: enable
  - 73: disable
  - 74: clear
  - 75: set
  - 76: end-of-service
  - 77: spurious vector

  Read data appears on the clock after the read strobe, and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt source inputs, synchronous to clk |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fast_req | output | 1 | Fast interrupt request, active high |
| norm_req | output | 1 | Normal interrupt request, active high |

## Verification
Pending bits are set one clock after an input change. The request lines are combinational from the pending bits, so both are due one clock after the input change. Command writes are due one clock after the write strobe, and read data is due one clock after the read strobe; a read's side effects take hold on that same clock. The bench drives inputs on falling edges and samples on the falling edge after the register that carries each result. It compares against a priority model computed in the bench, checking the full winner order of a 31-source sweep and an eight-level nesting sequence.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'b00,
    TRIG_FALL     = 2'b01,
    TRIG_HIGH_LVL = 2'b10,
    TRIG_RISE     = 2'b11
  } trig_e;

  localparam int unsigned PRIO_LSB = 0;
  localparam int unsigned TRIG_LSB = 5;

  // offsets above the control base
  localparam logic [3:0] OFS_IRQ_VEC = 4'd0;
  localparam logic [3:0] OFS_FIQ_VEC = 4'd1;
  localparam logic [3:0] OFS_STATUS  = 4'd2;
  localparam logic [3:0] OFS_PEND    = 4'd3;
  localparam logic [3:0] OFS_MASK    = 4'd4;
  localparam logic [3:0] OFS_CORE    = 4'd5;
  localparam logic [3:0] OFS_EN      = 4'd8;
  localparam logic [3:0] OFS_DIS     = 4'd9;
  localparam logic [3:0] OFS_CLR     = 4'd10;
  localparam logic [3:0] OFS_SET     = 4'd11;
  localparam logic [3:0] OFS_EOI     = 4'd12;
  localparam logic [3:0] OFS_SPUR    = 4'd13;
endpackage

// File: rtl/vic_src_bank.sv
`timescale 1ns/1ps
module vic_src_bank import vic_pkg::*; #(
  parameter int unsigned NSRC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_in,
  input  logic [NSRC-1:0][1:0] trig,
  input  logic [NSRC-1:0]      sw_set,
  input  logic [NSRC-1:0]      sw_clr,
  input  logic [NSRC-1:0]      ack,
  output logic [NSRC-1:0]      pend
);
  logic [NSRC-1:0] src_q, pend_q, pend_d, hit, edge_m;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      case (trig_e'(trig[i]))
        TRIG_LOW_LVL:  hit[i] = ~src_in[i];
        TRIG_HIGH_LVL: hit[i] = src_in[i];
        TRIG_FALL:     hit[i] = src_q[i] & ~src_in[i];
        TRIG_RISE:     hit[i] = ~src_q[i] & src_in[i];
        default:       hit[i] = 1'b0;
      endcase
      edge_m[i] = trig[i][0];
      pend_d[i] = edge_m[i] ? ((pend_q[i] & ~(sw_clr[i] | ack[i])) | hit[i] | sw_set[i])
                            : hit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_in;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3: a latched edge survives until cleared or acknowledged
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(edge_m & pend_q & ~(sw_clr | ack)))
              == $past(edge_m & pend_q & ~(sw_clr | ack))));
endmodule

// File: rtl/vic_arbiter.sv
`timescale 1ns/1ps
module vic_arbiter #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned PRIOW = 3,
  parameter int unsigned IDW   = 5,
  parameter int unsigned FIRST = 1
) (
  input  logic [NSRC-1:0]            elig,
  input  logic [NSRC-1:0][PRIOW-1:0] prio,
  output logic                       valid,
  output logic [IDW-1:0]             win_id,
  output logic [PRIOW-1:0]           win_prio
);
  always_comb begin
    valid    = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int i = FIRST; i < NSRC; i++) begin
      if (elig[i] && (!valid || prio[i] > win_prio)) begin
        valid    = 1'b1;
        win_id   = IDW'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_level_stack.sv
`timescale 1ns/1ps
module vic_level_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PRIOW = 3,
  parameter int unsigned IDW   = 5,
  parameter int unsigned CNTW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [PRIOW-1:0] push_prio,
  input  logic [IDW-1:0]   push_id,
  output logic             empty,
  output logic [PRIOW-1:0] top_prio,
  output logic [IDW-1:0]   top_id,
  output logic [CNTW-1:0]  depth
);
  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][PRIOW-1:0] prio_q, prio_d;
  logic [DEPTH-1:0][IDW-1:0]   id_q, id_d;
  logic [CNTW-1:0]             cnt_q, cnt_d;
  logic [PTRW-1:0]             top_ptr, wr_ptr;
  logic                        full;

  assign full    = (cnt_q == CNTW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ptr  = cnt_q[PTRW-1:0];
  assign top_ptr = PTRW'(cnt_q - 1'b1);

  always_comb begin
    prio_d = prio_q;
    id_d   = id_q;
    cnt_d  = cnt_q;
    if (push && !full) begin
      prio_d[wr_ptr] = push_prio;
      id_d[wr_ptr]   = push_id;
      cnt_d          = cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      id_q   <= '0;
      cnt_q  <= '0;
    end else if (push || pop) begin
      prio_q <= prio_d;
      id_q   <= id_d;
      cnt_q  <= cnt_d;
    end
  end

  assign top_prio = prio_q[top_ptr];
  assign top_id   = id_q[top_ptr];
  assign depth    = cnt_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_push_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !empty) |-> (push_prio > top_prio));
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl import vic_pkg::*; #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NLVL  = 8,
  parameter int unsigned VECW  = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned ADDRW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [ADDRW-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             fast_req,
  output logic             norm_req
);
  localparam int unsigned PRIOW    = $clog2(NLVL);
  localparam int unsigned IDW      = $clog2(NSRC);
  localparam int unsigned CNTW     = $clog2(NLVL + 1);
  localparam int unsigned VEC_BASE = NSRC;
  localparam int unsigned CTL_BASE = 2 * NSRC;

  // ---------------- bus decode ----------------
  logic             wr_en, rd_en, is_mode, is_vec, is_ctl;
  logic [IDW-1:0]   mode_idx, vec_idx;
  logic [ADDRW-1:0] ctl_ofs;
  logic [3:0]       ctl_sel;

  assign wr_en    = bus_en & bus_we;
  assign rd_en    = bus_en & ~bus_we;
  assign is_mode  = bus_addr < ADDRW'(VEC_BASE);
  assign is_vec   = !is_mode && (bus_addr < ADDRW'(CTL_BASE));
  assign mode_idx = IDW'(bus_addr);
  assign vec_idx  = IDW'(bus_addr - ADDRW'(VEC_BASE));
  assign ctl_ofs  = bus_addr - ADDRW'(CTL_BASE);
  assign ctl_sel  = ctl_ofs[3:0];
  assign is_ctl   = !is_mode && !is_vec && (ctl_ofs[ADDRW-1:4] == '0);

  logic cmd_en, cmd_dis, cmd_clr, cmd_set, cmd_eoi, spur_wr, rd_ivr, rd_fvr;
  assign cmd_en  = wr_en & is_ctl & (ctl_sel == OFS_EN);
  assign cmd_dis = wr_en & is_ctl & (ctl_sel == OFS_DIS);
  assign cmd_clr = wr_en & is_ctl & (ctl_sel == OFS_CLR);
  assign cmd_set = wr_en & is_ctl & (ctl_sel == OFS_SET);
  assign cmd_eoi = wr_en & is_ctl & (ctl_sel == OFS_EOI);
  assign spur_wr = wr_en & is_ctl & (ctl_sel == OFS_SPUR);
  assign rd_ivr  = rd_en & is_ctl & (ctl_sel == OFS_IRQ_VEC);
  assign rd_fvr  = rd_en & is_ctl & (ctl_sel == OFS_FIQ_VEC);

  // ---------------- configuration state ----------------
  logic [NSRC-1:0][PRIOW-1:0] prio_q, prio_d;
  logic [NSRC-1:0][1:0]       trig_q, trig_d;
  logic [NSRC-1:0][VECW-1:0]  vec_q, vec_d;
  logic [NSRC-1:0]            mask_q, mask_d;
  logic [VECW-1:0]            spur_q, spur_d;
  logic [DW-1:0]              rdata_q, rdata_d;
  logic                       cfg_wr, mask_wr;

  assign cfg_wr  = wr_en & (is_mode | is_vec);
  assign mask_wr = cmd_en | cmd_dis;

  always_comb begin
    prio_d = prio_q;
    trig_d = trig_q;
    vec_d  = vec_q;
    mask_d = mask_q;
    spur_d = spur_q;
    if (wr_en && is_mode) begin
      prio_d[mode_idx] = bus_wdata[PRIO_LSB +: PRIOW];
      trig_d[mode_idx] = bus_wdata[TRIG_LSB +: 2];
    end
    if (wr_en && is_vec) vec_d[vec_idx] = bus_wdata[VECW-1:0];
    if (cmd_en)  mask_d = mask_q | bus_wdata[NSRC-1:0];
    if (cmd_dis) mask_d = mask_q & ~bus_wdata[NSRC-1:0];
    if (spur_wr) spur_d = bus_wdata[VECW-1:0];
  end

  // ---------------- sources, selection, nesting ----------------
  logic [NSRC-1:0]  pend, elig, ack, sw_set, sw_clr;
  logic             win_valid, stk_empty;
  logic [IDW-1:0]   win_id, top_id;
  logic [PRIOW-1:0] win_prio, top_prio;
  logic [CNTW-1:0]  stk_depth;

  assign sw_set = cmd_set ? bus_wdata[NSRC-1:0] : '0;
  assign sw_clr = cmd_clr ? bus_wdata[NSRC-1:0] : '0;
  assign elig   = pend & mask_q;

  vic_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .trig(trig_q),
    .sw_set(sw_set), .sw_clr(sw_clr), .ack(ack), .pend(pend)
  );

  vic_arbiter #(.NSRC(NSRC), .PRIOW(PRIOW), .IDW(IDW), .FIRST(1)) u_arb (
    .elig(elig), .prio(prio_q), .valid(win_valid), .win_id(win_id), .win_prio(win_prio)
  );

  assign norm_req = win_valid && (stk_empty || (win_prio > top_prio));
  assign fast_req = elig[0];

  always_comb begin
    ack = '0;
    if (rd_ivr && norm_req) ack[win_id] = 1'b1;
    if (rd_fvr && fast_req) ack[0]      = 1'b1;
  end

  vic_level_stack #(.DEPTH(NLVL), .PRIOW(PRIOW), .IDW(IDW), .CNTW(CNTW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(rd_ivr && norm_req), .pop(cmd_eoi),
    .push_prio(win_prio), .push_id(win_id), .empty(stk_empty),
    .top_prio(top_prio), .top_id(top_id), .depth(stk_depth)
  );

  // ---------------- read mux ----------------
  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      if (is_mode) begin
        rdata_d[PRIO_LSB +: PRIOW] = prio_q[mode_idx];
        rdata_d[TRIG_LSB +: 2]     = trig_q[mode_idx];
      end else if (is_vec) begin
        rdata_d[VECW-1:0] = vec_q[vec_idx];
      end else if (is_ctl) begin
        case (ctl_sel)
          OFS_IRQ_VEC: rdata_d[VECW-1:0] = norm_req ? vec_q[win_id] : spur_q;
          OFS_FIQ_VEC: rdata_d[VECW-1:0] = fast_req ? vec_q[0] : spur_q;
          OFS_STATUS:  rdata_d[IDW-1:0]  = stk_empty ? '0 : top_id;
          OFS_PEND:    rdata_d[NSRC-1:0] = pend;
          OFS_MASK:    rdata_d[NSRC-1:0] = mask_q;
          OFS_CORE:    rdata_d[1:0]      = {norm_req, fast_req};
          OFS_SPUR:    rdata_d[VECW-1:0] = spur_q;
          default:     rdata_d           = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      trig_q  <= '0;
      vec_q   <= '0;
      mask_q  <= '0;
      spur_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (cfg_wr) begin
        prio_q <= prio_d;
        trig_q <= trig_d;
        vec_q  <= vec_d;
      end
      if (mask_wr) mask_q <= mask_d;
      if (spur_wr) spur_q <= spur_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  assert_mask_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  assert_mask_dis_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));
  assert_winner_elig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req |-> (pend[win_id] && mask_q[win_id] && (win_id != '0)));
  assert_push_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && norm_req) |=> (stk_depth == $past(stk_depth) + 1'b1));
  assert_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && !norm_req) |=> (bus_rdata[VECW-1:0] == $past(spur_q)));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  localparam int A_IVR = 64, A_FVR = 65, A_STAT = 66, A_PEND = 67, A_MASK = 68,
                 A_CORE = 69, A_EN = 72, A_DIS = 73, A_CLR = 74, A_SET = 75,
                 A_EOI = 76, A_SPUR = 77;

  logic        clk, rst_n, en, we, fast, norm;
  logic [31:0] src, wdata, rdata, rv;
  logic [7:0]  addr;
  int n_chk, n_fail;

  vec_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_en(en), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .fast_req(fast), .norm_req(norm)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    en = 1'b1; we = 1'b1; addr = 8'(a); wdata = d;
    tick();
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    en = 1'b1; we = 1'b0; addr = 8'(a);
    tick();
    en = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] m);
    src = src & ~m; tick();
    src = src | m;  tick();
  endtask

  function automatic int pr(input int i);
    return (i * 3 + 1) % 8;
  endfunction

  function automatic logic [31:0] vec_of(input int i);
    return 32'h1000 + 32'(i * 4);
  endfunction

  function automatic int pick(input logic [31:0] pm);
    int w = -1, bp = -1;
    for (int i = 1; i < 32; i++)
      if (pm[i] && pr(i) > bp) begin w = i; bp = pr(i); end
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] model;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; en = 1'b0; we = 1'b0; addr = '0; wdata = '0; src = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 fast", 32'(fast), 0);
    chk("R1 norm", 32'(norm), 0);
    chk("R1 rdata", rdata, 0);
    rd(A_PEND, rv); chk("R1 pending", rv, 0);
    rd(A_MASK, rv); chk("R1 mask", rv, 0);
    rd(A_STAT, rv); chk("R1 status", rv, 0);
    rd(A_CORE, rv); chk("R1 core", rv, 0);

    // R12 address map and R2 field layout
    for (int i = 0; i < 32; i++) wr(32 + i, vec_of(i));
    for (int i = 0; i < 32; i++) begin rd(32 + i, rv); chk("R12 vector", rv, vec_of(i)); end
    for (int i = 0; i < 32; i++) wr(i, 32'hFFFF_FF18 | 32'((i & 3) << 5) | 32'(i & 7));
    for (int i = 0; i < 32; i++) begin
      rd(i, rv); chk("R2 mode fields", rv, 32'((i & 3) << 5) | 32'(i & 7));
    end

    // all rising edge, priority pr(i); clear leftovers
    for (int i = 0; i < 32; i++) wr(i, 32'h60 | 32'(pr(i)));
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_PEND, rv); chk("R5 clear all", rv, 0);

    // R6/R7/R8 priority sweep over all 31 normal sources
    wr(A_EN, 32'hFFFF_FFFE);
    rd(A_MASK, rv); chk("R4 mask enable", rv, 32'hFFFF_FFFE);
    chk("R4 no request before edge", 32'(norm), 0);
    pulse(32'hFFFF_FFFE);
    model = 32'hFFFF_FFFE;
    rd(A_PEND, rv); chk("R3 edges latched", rv, model);
    for (int k = 0; k < 31; k++) begin
      int w;
      w = pick(model);
      chk("R6 request up", 32'(norm), 1);
      rd(A_IVR, rv); chk("R6 winner vector", rv, vec_of(w));
      model[w] = 1'b0;
      chk("R7 request drops", 32'(norm), 0);
      rd(A_STAT, rv); chk("R8 status id", rv, 32'(w));
      rd(A_PEND, rv); chk("R7 edge pending cleared", rv, model);
      wr(A_EOI, 0);
    end
    rd(A_STAT, rv); chk("R8 status idle", rv, 0);
    wr(A_DIS, 32'hFFFF_FFFF);
    rd(A_MASK, rv); chk("R4 mask disable", rv, 0);

    // R7/R8 nesting with equal and higher priorities
    wr(3, 32'h62); wr(4, 32'h62); wr(9, 32'h65);
    wr(A_EN, (32'd1 << 3) | (32'd1 << 4) | (32'd1 << 9));
    pulse(32'd1 << 3);
    chk("R7 first request", 32'(norm), 1);
    rd(A_IVR, rv); chk("R7 vector 3", rv, vec_of(3));
    pulse(32'd1 << 4);
    chk("R7 equal priority blocked", 32'(norm), 0);
    pulse(32'd1 << 9);
    chk("R7 higher priority preempts", 32'(norm), 1);
    rd(A_IVR, rv); chk("R7 vector 9", rv, vec_of(9));
    rd(A_STAT, rv); chk("R8 nested id", rv, 9);
    wr(A_EOI, 0);
    rd(A_STAT, rv); chk("R8 restored id", rv, 3);
    chk("R8 still blocked", 32'(norm), 0);
    wr(A_EOI, 0);
    chk("R8 request after unwind", 32'(norm), 1);
    rd(A_CORE, rv); chk("R11 normal bit", rv, 2);
    rd(A_IVR, rv); chk("R6 vector 4", rv, vec_of(4));
    wr(A_EOI, 0);

    // R8 eight-level nesting
    wr(A_DIS, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) wr(10 + k, 32'h60 | 32'(k));
    wr(A_EN, 32'h0003_FC00);
    for (int k = 0; k < 8; k++) begin
      pulse(32'd1 << (10 + k));
      chk("R8 nest request", 32'(norm), 1);
      rd(A_IVR, rv); chk("R8 nest vector", rv, vec_of(10 + k));
    end
    for (int j = 7; j >= 0; j--) begin
      rd(A_STAT, rv); chk("R8 unwind id", rv, 32'(10 + j));
      wr(A_EOI, 0);
    end
    rd(A_STAT, rv); chk("R8 fully unwound", rv, 0);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R4 masked source stays silent until enabled
    pulse(32'd1 << 9);
    chk("R4 masked silent", 32'(norm), 0);
    wr(A_EN, 32'd1 << 9);
    chk("R4 request after enable", 32'(norm), 1);
    rd(A_IVR, rv); chk("R4 vector 9", rv, vec_of(9));
    wr(A_EOI, 0);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R10 spurious vector
    wr(A_SPUR, 32'h0000_DEAD);
    rd(A_SPUR, rv); chk("R10 readback", rv, 32'h0000_DEAD);
    rd(A_IVR, rv); chk("R10 idle read", rv, 32'h0000_DEAD);
    rd(A_STAT, rv); chk("R10 no push", rv, 0);
    wr(A_EN, 32'd1 << 3);
    pulse(32'd1 << 3);
    chk("R10 request raised", 32'(norm), 1);
    wr(A_CLR, 32'd1 << 3);
    chk("R5 clear drops request", 32'(norm), 0);
    rd(A_IVR, rv); chk("R10 vanished request", rv, 32'h0000_DEAD);
    rd(A_STAT, rv); chk("R10 status unchanged", rv, 0);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R9/R11 fast line
    wr(A_EN, 32'd1);
    pulse(32'd1);
    chk("R9 fast up", 32'(fast), 1);
    chk("R9 normal untouched", 32'(norm), 0);
    rd(A_CORE, rv); chk("R11 fast bit", rv, 1);
    rd(A_FVR, rv); chk("R9 fast vector", rv, vec_of(0));
    chk("R9 fast cleared", 32'(fast), 0);
    rd(A_FVR, rv); chk("R10 fast spurious", rv, 32'h0000_DEAD);
    wr(A_DIS, 32'd1);

    // R2 level sources
    rd(A_PEND, rv); chk("R2 nothing pending", rv, 0);
    wr(5, 32'h41);
    tick();
    rd(A_PEND, rv); chk("R2 high level set", rv, 32'd1 << 5);
    src[5] = 1'b0; tick();
    rd(A_PEND, rv); chk("R2 high level gone", rv, 0);
    wr(6, 32'h01);
    src[6] = 1'b0; tick();
    rd(A_PEND, rv); chk("R2 low level set", rv, 32'd1 << 6);
    src[6] = 1'b1; tick();
    rd(A_PEND, rv); chk("R2 low level gone", rv, 0);

    // R5 set/clear
    wr(A_SET, 32'd1 << 5);
    rd(A_PEND, rv); chk("R5 set ignored on level", rv, 0);
    wr(A_SET, 32'd1 << 3);
    rd(A_PEND, rv); chk("R5 set on edge", rv, 32'd1 << 3);
    wr(A_CLR, 32'd1 << 3);
    rd(A_PEND, rv); chk("R5 clear on edge", rv, 0);

    // R3 falling edge
    wr(20, 32'h23);
    src[20] = 1'b0; tick();
    rd(A_PEND, rv); chk("R3 falling edge", rv, 32'd1 << 20);
    src[20] = 1'b1; tick(); tick();
    rd(A_PEND, rv); chk("R3 edge held", rv, 32'd1 << 20);
    wr(A_CLR, 32'd1 << 20);
    rd(A_PEND, rv); chk("R3 edge cleared", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule